// File: doc/BRIEF.md
# Two-Line Adaptive Comb Luma/Chroma Separator

This block splits a stream of 8-bit composite colour video samples into a luminance stream and a chrominance stream. The samples arrive at four times the colour subcarrier frequency, and the whole block runs on that sampling clock. A sample is accepted on each cycle where `in_valid` is high. The block keeps one full line of accepted samples in an internal delay memory. Each new sample can therefore be compared with the sample at the same position on the line before.

Both the current line and the delayed line pass through a short band-pass filter that peaks at the subcarrier. At that sampling rate the subcarrier flips sign from one line to the next. When the two filtered values nearly cancel, the lines are taken to correlate, and the chroma estimate is half their difference. This is a two-line comb. When they do not cancel, the estimate falls back to the band-passed current sample alone. This choice is made again for every sample, which limits dot crawl and cross-colour at vertical edges. Luma is the delay-aligned composite minus the chroma estimate. A kill input turns separation off for monochrome material.

Top module: `yc_comb_sep`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `out_valid`=0, `y_out`=0 and `c_out`=128. The line memory and the tap registers are cleared to zero.
- R2: `out_valid` is high exactly in the cycle after each accepted sample. In a cycle with no accepted sample, `y_out` and `c_out` keep their values.
- R3: For accepted sample index n, with x(k) the k-th previous accepted sample (x(k)=0 before the first one), the band-pass value is bc = floor((2·x(n-2) − x(n) − x(n-4)) / 4). Every output belongs to the centre sample x(n-2).
- R4: With p(k) = x(k − LINE_LEN), the delayed-line value bp is found the same way. If |bc + bp| < `comb_thresh`, chroma = floor((bc − bp) / 2).
- R5: If |bc + bp| ≥ `comb_thresh`, chroma = bc.
- R6: `y_out` = x(n-2) − chroma, clamped to the range 0..255.
- R7: `c_out` = chroma + 128, which is two's-complement chroma with its sign bit inverted.
- R8: When `kill` is high with an accepted sample, `y_out` = x(n-2) unmodified and `c_out` = 128.
- R9: The line memory advances only on accepted samples, so gaps in `in_valid` do not shift the line alignment.
- R10: `comb_thresh` = 0 forces the fallback of R5 on every sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock at four times the subcarrier |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Composite sample strobe |
| comp_in | input | 8 | Composite sample, unsigned |
| kill | input | 1 | Separation bypass for monochrome input |
| comb_thresh | input | 8 | Cancellation limit for choosing the comb |
| out_valid | output | 1 | Output sample strobe |
| y_out | output | 8 | Luminance sample, unsigned |
| c_out | output | 8 | Chrominance sample, offset by 128 |

## Verification
On every cycle the assertions check the strobe timing, the holding of outputs between accepted samples, the reset state, and the neutral chroma under kill. The arithmetic can only be shown by the bench scenarios, which compare results against an independent model. These cover the comb-versus-fallback decision, the one-line alignment across valid gaps, luma saturation at both ends, and the zero-threshold case. They use phase-continuous subcarrier patterns that invert line to line, line-locked patterns that do not invert, and random material.

// File: rtl/yc_comb_sep.sv
module yc_comb_sep #(
  parameter int LINE_LEN = 910,
  localparam int PTR_W = $clog2(LINE_LEN)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic [7:0] comp_in,
  input  logic       kill,
  input  logic [7:0] comb_thresh,
  output logic       out_valid,
  output logic [7:0] y_out,
  output logic [7:0] c_out
);

  logic [7:0]       line_mem [LINE_LEN];
  logic [PTR_W-1:0] wr_ptr;
  logic [7:0]       cur_tap [4];
  logic [7:0]       prv_tap [4];
  logic [7:0]       prv_new;

  assign prv_new = line_mem[wr_ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINE_LEN; i++) line_mem[i] <= '0;
    end else if (in_valid) begin
      line_mem[wr_ptr] <= comp_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      for (int i = 0; i < 4; i++) begin
        cur_tap[i] <= '0;
        prv_tap[i] <= '0;
      end
    end else if (in_valid) begin
      wr_ptr <= (wr_ptr == PTR_W'(LINE_LEN - 1)) ? '0 : wr_ptr + 1'b1;
      cur_tap[0] <= comp_in;
      prv_tap[0] <= prv_new;
      for (int i = 1; i < 4; i++) begin
        cur_tap[i] <= cur_tap[i-1];
        prv_tap[i] <= prv_tap[i-1];
      end
    end
  end

  logic signed [10:0] cur_acc, prv_acc;
  logic signed [7:0]  bc, bp;
  logic signed [8:0]  pair_sum, pair_dif;
  logic [8:0]         pair_mag;
  logic               use_comb;
  logic signed [7:0]  chroma;
  logic signed [9:0]  luma_raw;
  logic [7:0]         luma_sat;

  assign cur_acc = $signed({2'b00, cur_tap[1], 1'b0})
                 - $signed({3'b000, comp_in}) - $signed({3'b000, cur_tap[3]});
  assign prv_acc = $signed({2'b00, prv_tap[1], 1'b0})
                 - $signed({3'b000, prv_new}) - $signed({3'b000, prv_tap[3]});
  assign bc = cur_acc[9:2];
  assign bp = prv_acc[9:2];

  assign pair_sum = 9'(bc) + 9'(bp);
  assign pair_dif = 9'(bc) - 9'(bp);
  assign pair_mag = pair_sum[8] ? 9'(-pair_sum) : pair_sum;
  assign use_comb = pair_mag < {1'b0, comb_thresh};
  assign chroma   = use_comb ? pair_dif[8:1] : bc;

  assign luma_raw = $signed({2'b00, cur_tap[1]}) - 10'(chroma);
  assign luma_sat = luma_raw[9] ? 8'd0 : (luma_raw[8] ? 8'd255 : luma_raw[7:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      y_out     <= 8'd0;
      c_out     <= 8'd128;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        y_out <= kill ? cur_tap[1] : luma_sat;
        c_out <= kill ? 8'd128 : {~chroma[7], chroma[6:0]};
      end
    end
  end

endmodule

// File: rtl/yc_comb_sep_chk.sv
module yc_comb_sep_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       kill,
  input logic       out_valid,
  input logic [7:0] y_out,
  input logic [7:0] c_out
);

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (!out_valid && y_out == 8'd0 && c_out == 8'd128)); // R1

  AST_VALID_TRACK: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R2

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(y_out) && $stable(c_out))); // R2

  AST_KILL_NEUTRAL: assert property (@(posedge clk) disable iff (rst)
    (in_valid && kill) |=> c_out == 8'd128); // R8

endmodule

bind yc_comb_sep yc_comb_sep_chk u_chk (.*);

// File: tb/yc_comb_sep_bench.sv
`timescale 1ns/1ps
module yc_comb_sep_bench;
  localparam int L = 910;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, in_valid, kill, out_valid;
  logic [7:0] comp_in, comb_thresh, y_out, c_out;

  yc_comb_sep #(.LINE_LEN(L)) u_yc_comb_sep (
    .clk(clk), .rst(rst), .in_valid(in_valid), .comp_in(comp_in), .kill(kill),
    .comb_thresh(comb_thresh), .out_valid(out_valid), .y_out(y_out), .c_out(c_out));

  int s [16384];
  int n = 0, errs = 0, checks = 0, nsat = 0;
  int y_last = 0, c_last = 128;
  bit done = 0;

  function automatic int g(int i);
    return (i < 0) ? 0 : s[i];
  endfunction

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d (sample %0d)", r, act, exp, n);
    end
  endtask

  task automatic push(string r, bit v, int x, bit k, int th);
    int bc, bp, m, ch, ye, ce;
    comp_in = 8'(x); in_valid = v; kill = k; comb_thresh = 8'(th);
    ye = y_last; ce = c_last;
    if (v) begin
      s[n] = x;
      bc = (2*g(n-2) - g(n) - g(n-4)) >>> 2;
      bp = (2*g(n-2-L) - g(n-L) - g(n-4-L)) >>> 2;
      m = bc + bp; if (m < 0) m = -m;
      if (k) begin ye = g(n-2); ce = 128; end
      else begin
        ch = (m < th) ? ((bc - bp) >>> 1) : bc;
        ye = g(n-2) - ch;
        if (ye < 0 || ye > 255) nsat++;
        ye = (ye < 0) ? 0 : (ye > 255 ? 255 : ye);
        ce = ch + 128;
      end
    end
    @(negedge clk);
    chk({r, " R2 valid"}, out_valid, v);
    chk({r, " luma"}, y_out, ye);
    chk({r, " chroma"}, c_out, ce);
    if (v) n++;
    y_last = ye; c_last = ce;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int sv [4];
    sv = '{1, 0, -1, 0};
    void'($urandom(32'd20240611));
    rst = 1; in_valid = 0; kill = 0; comp_in = 0; comb_thresh = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 reset valid", out_valid, 0);
    chk("R1 reset luma", y_out, 0);
    chk("R1 reset chroma", c_out, 128);

    // R9: first line random with gaps
    for (int i = 0; i < L; i++) begin
      if ($urandom_range(0, 3) == 0) push("R9 gap", 0, $urandom_range(0, 255), 0, 20);
      push("R9 R3 line0", 1, $urandom_range(0, 255), 0, 20);
    end
    // R4 R7: phase-continuous subcarrier, inverts line to line
    for (int i = 0; i < 2*L; i++)
      push("R4 R7 inverted", 1, 120 + 60*sv[n % 4], 0, 16);
    // R5: line-locked subcarrier, no inversion
    for (int l = 0; l < 2; l++)
      for (int i = 0; i < L; i++)
        push("R5 locked", 1, 120 + 60*sv[i % 4], 0, 8);
    // R6: random with comb always chosen, drives saturation
    for (int i = 0; i < L; i++) begin
      if ($urandom_range(0, 7) == 0) push("R6 R9 gap", 0, 0, 0, 255);
      push("R6 sat", 1, ($urandom_range(0, 1) != 0) ? $urandom_range(0, 20) : $urandom_range(235, 255), 0, 255);
    end
    // R8: kill bypass
    for (int i = 0; i < 300; i++) push("R8 kill", 1, $urandom_range(0, 255), 1, $urandom_range(0, 255));
    // R10: zero threshold
    for (int i = 0; i < L; i++) push("R10 thresh0", 1, $urandom_range(0, 255), 0, 0);
    // mixed random
    for (int i = 0; i < 600; i++)
      push("R3 R4 R5 mix", $urandom_range(0, 4) != 0, $urandom_range(0, 255),
           $urandom_range(0, 15) == 0, $urandom_range(0, 64));
    chk("R6 saturation exercised", nsat > 0, 1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule